// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM device from power-up to a usable state before any normal access is allowed. On the first cycle after reset it captures the static configuration: a timing word holding the CAS latency and a two-bit refresh-enable field, two bank-group configuration words, and an optional precomputed mode value. It then issues a fixed series of commands on a one-cycle-pulse command interface. Each command word carries a two-bit command code and a mode-register payload that starts at bit 2.

While the sequence runs, the applied timing word has its refresh field forced to zero, so periodic refresh stays off. After the last command has had its minimum spacing, the full timing word is applied. In that same cycle refresh is enabled and a sticky done flag rises. All delays come from one down-counter whose reload values are derived from the clock frequency parameter.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: Reset holds `cmd_valid`, `init_done` and `refresh_en` low. On the first clock edge after reset, `grp0_out` and `grp1_out` take the bank-group words, and `timing_out` takes `cfg_timing` with its refresh field (bits [REF_LSB+1:REF_LSB], REF_LSB = 12 by default) cleared. This happens before any command is issued.
- R2: The first command is a single NOP, with command word 0 (code 0 in bits [1:0], no payload).
- R3: After the NOP come exactly WAIT_200US idle cycles before the next command, where WAIT_200US = ceil(CLK_HZ × 200 µs).
- R4: After that wait, the commands are one PRECHARGE (code 1), then eight AUTO REFRESH (code 2), then one MODE REGISTER SET (code 3), in that order, and nothing else.
- R5: Successive commands after the NOP are separated by exactly WAIT_CMD idle cycles, where WAIT_CMD = ceil(CLK_HZ × 80 ns) with a minimum of 1.
- R6: `cmd_valid` is high for exactly one cycle per command.
- R7: Every command after the NOP has `cmd_word` = payload | code. With no override, the payload is the base value shifted left by 2. The base value is 0x40 when `cfg_timing[2:0]` equals 2 and 0x60 otherwise.
- R8: When bit 9 of `cfg_grp0` is 1 (16-bit bus), the derived payload is halved: 0x080 for CL2 and 0x0C0 for CL3, against 0x100 and 0x180 for a 32-bit bus.
- R9: A nonzero `cfg_mode_ovr` replaces the derived payload verbatim on every command after the NOP.
- R10: `init_done` rises exactly WAIT_CMD + 1 cycles after the MODE REGISTER SET pulse. In that same cycle, `timing_out` becomes the full `cfg_timing`, and `refresh_en` becomes 1 exactly when the refresh field is nonzero.
- R11: Once `init_done` is high, it stays high until reset and no further command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_timing | input | 32 | Timing word: CAS latency in [2:0], refresh field at REF_LSB |
| cfg_grp0 | input | 32 | Bank-group 0 configuration; bit 9 set means 16-bit bus |
| cfg_grp1 | input | 32 | Bank-group 1 configuration |
| cfg_mode_ovr | input | 32 | Precomputed payload; zero selects automatic derivation |
| grp0_out | output | 32 | Applied bank-group 0 configuration |
| grp1_out | output | 32 | Applied bank-group 1 configuration |
| timing_out | output | 32 | Applied timing word |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_word | output | 32 | Command code in [1:0] ORed with the mode payload |
| refresh_en | output | 1 | Periodic refresh enable |
| init_done | output | 1 | Initialization complete, sticky |

## Verification
The assertions assume the configuration inputs stay constant from reset release until `init_done`. They also assume that an override value has zero in bits [1:0], so that ORing it with the command code cannot change the code. The ordering checks further assume that WAIT_CMD does not exceed WAIT_200US. The stimulus changes the configuration only while reset is held, uses an override with clear low bits, and sets the clock parameter so that both waits are short but distinct.

// File: rtl/sdram_pwrup_pkg.sv
package sdram_pwrup_pkg;

    localparam int WORD_W   = 32;
    localparam int MODE_LSB = 2;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PRE  = 2'd1,
        CMD_AREF = 2'd2,
        CMD_MRS  = 2'd3
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_LATCH,
        ST_NOP,
        ST_WAIT,
        ST_ISSUE,
        ST_FINISH,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
    } cmd_out_t;

    function automatic longint ceil_div(input longint num, input longint den);
        return (num + den - 1) / den;
    endfunction

    // Base mode value from CAS latency, placed at MODE_LSB, halved for a 16-bit bus.
    function automatic logic [WORD_W-1:0] mode_payload(input logic [2:0] cas, input logic bus16);
        logic [WORD_W-1:0] v;
        v = (cas == 3'd2) ? 32'h40 : 32'h60;
        v = v << MODE_LSB;
        if (bus16) v = v >> 1;
        return v;
    endfunction

    // Position in the post-wait sequence selects the command.
    function automatic sd_cmd_e seq_code(input int idx, input int last);
        if (idx == 0)    return CMD_PRE;
        if (idx == last) return CMD_MRS;
        return CMD_AREF;
    endfunction

endpackage

// File: rtl/sdram_pwrup_wait.sv
module sdram_pwrup_wait #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)           cnt <= '0;
        else if (load)     cnt <= load_val;
        else if (cnt != 0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    AST_CNT_DEC: assert property (@(posedge clk) disable iff (rst)
        (!load && !zero) |=> (cnt == $past(cnt) - 1'b1)); // R5
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val))); // R3

endmodule

// File: rtl/sdram_pwrup_mode.sv
module sdram_pwrup_mode
    import sdram_pwrup_pkg::*;
#(
    parameter int BUS16_BIT = 9
) (
    input  logic [WORD_W-1:0] cfg_timing,
    input  logic [WORD_W-1:0] cfg_grp0,
    input  logic [WORD_W-1:0] cfg_mode_ovr,
    output logic [WORD_W-1:0] payload
);
    logic [WORD_W-1:0] derived;

    always_comb begin
        derived = mode_payload(cfg_timing[2:0], cfg_grp0[BUS16_BIT]);
        payload = (cfg_mode_ovr != '0) ? cfg_mode_ovr : derived;
    end

    AST_PAY_ALIGNED: assert final ((cfg_mode_ovr != '0) || (derived[1:0] == 2'b00)); // R7

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_pwrup_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int NUM_AREF  = 8,
    parameter int REF_LSB   = 12,
    parameter int BUS16_BIT = 9
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] cfg_timing,
    input  logic [31:0] cfg_grp0,
    input  logic [31:0] cfg_grp1,
    input  logic [31:0] cfg_mode_ovr,
    output logic [31:0] grp0_out,
    output logic [31:0] grp1_out,
    output logic [31:0] timing_out,
    output logic        cmd_valid,
    output logic [31:0] cmd_word,
    output logic        refresh_en,
    output logic        init_done
);
    localparam longint W200_L   = ceil_div(longint'(CLK_HZ) * 200, 1_000_000);
    localparam longint WCMD_L   = ceil_div(longint'(CLK_HZ) * 80, 1_000_000_000);
    localparam int     WAIT_200US = (W200_L < 1) ? 1 : int'(W200_L);
    localparam int     WAIT_CMD   = (WCMD_L < 1) ? 1 : int'(WCMD_L);
    localparam int     CNT_W    = $clog2(WAIT_200US + 1);
    localparam int     SEQ_LEN  = NUM_AREF + 2;
    localparam int     IDX_W    = $clog2(SEQ_LEN + 1);
    localparam logic [WORD_W-1:0] REF_MASK = 32'h3 << REF_LSB;
    localparam logic [CNT_W-1:0]  LD_LONG  = CNT_W'(WAIT_200US - 1);
    localparam logic [CNT_W-1:0]  LD_SHORT = CNT_W'(WAIT_CMD - 1);

    seq_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] payload, payload_q, timing_full_q;
    cmd_out_t          cmd_q;
    logic              wait_load, wait_zero;
    logic [CNT_W-1:0]  wait_val;

    sdram_pwrup_mode #(.BUS16_BIT(BUS16_BIT)) mode_i (
        .cfg_timing  (cfg_timing),
        .cfg_grp0    (cfg_grp0),
        .cfg_mode_ovr(cfg_mode_ovr),
        .payload     (payload)
    );

    always_comb begin
        wait_load = (state == ST_NOP) || (state == ST_ISSUE);
        wait_val  = (state == ST_NOP) ? LD_LONG : LD_SHORT;
    end

    sdram_pwrup_wait #(.CNT_W(CNT_W)) wait_i (
        .clk     (clk),
        .rst     (rst),
        .load    (wait_load),
        .load_val(wait_val),
        .zero    (wait_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_LATCH;
            idx           <= '0;
            payload_q     <= '0;
            timing_full_q <= '0;
            grp0_out      <= '0;
            grp1_out      <= '0;
            timing_out    <= '0;
            cmd_q         <= '0;
            refresh_en    <= 1'b0;
            init_done     <= 1'b0;
        end else begin
            case (state)
                ST_LATCH: begin
                    grp0_out      <= cfg_grp0;
                    grp1_out      <= cfg_grp1;
                    timing_full_q <= cfg_timing;
                    timing_out    <= cfg_timing & ~REF_MASK;
                    payload_q     <= payload;
                    state         <= ST_NOP;
                end
                ST_NOP: begin
                    cmd_q.valid <= 1'b1;
                    cmd_q.word  <= WORD_W'(CMD_NOP);
                    state       <= ST_WAIT;
                end
                ST_WAIT: begin
                    cmd_q.valid <= 1'b0;
                    if (wait_zero)
                        state <= (idx == IDX_W'(SEQ_LEN)) ? ST_FINISH : ST_ISSUE;
                end
                ST_ISSUE: begin
                    cmd_q.valid <= 1'b1;
                    cmd_q.word  <= payload_q | WORD_W'(seq_code(int'(idx), SEQ_LEN - 1));
                    idx         <= idx + 1'b1;
                    state       <= ST_WAIT;
                end
                ST_FINISH: begin
                    timing_out <= timing_full_q;
                    refresh_en <= |(timing_full_q & REF_MASK);
                    init_done  <= 1'b1;
                    state      <= ST_DONE;
                end
                default: ;
            endcase
        end
    end

    assign cmd_valid = cmd_q.valid;
    assign cmd_word  = cmd_q.word;

    AST_REF_OFF_EARLY: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> !refresh_en); // R1
    AST_TIMING_MASKED: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> ((timing_out & REF_MASK) == '0)); // R1
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done); // R11
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        init_done |-> !cmd_valid); // R11
    AST_FULL_TIMING: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> (timing_out == timing_full_q)); // R10

endmodule

// File: tb/sdram_pwrup_seq_tb.sv
module sdram_pwrup_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 50_000_000;
    localparam int W200       = 10000;
    localparam int WCMD       = 4;
    localparam int NCMD       = 11;
    localparam logic [31:0] RMASK = 32'h0000_3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_timing = '0, cfg_grp0 = '0, cfg_grp1 = '0, cfg_mode_ovr = '0;
    logic [31:0] grp0_out, grp1_out, timing_out, cmd_word;
    logic        cmd_valid, refresh_en, init_done;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int n_cmd = 0;
    int done_t = -1;
    int pulse_err = 0;
    logic prev_valid = 1'b0;
    logic ref_at_done = 1'b0;
    int          t_cmd [16];
    logic [31:0] w_cmd [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_pwrup_seq #(.CLK_HZ(CLK_HZ)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_timing(cfg_timing), .cfg_grp0(cfg_grp0), .cfg_grp1(cfg_grp1),
        .cfg_mode_ovr(cfg_mode_ovr),
        .grp0_out(grp0_out), .grp1_out(grp1_out), .timing_out(timing_out),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .refresh_en(refresh_en), .init_done(init_done)
    );

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_valid && n_cmd < 16) begin
                t_cmd[n_cmd] = cyc;
                w_cmd[n_cmd] = cmd_word;
            end
            if (cmd_valid) n_cmd++;
            if (cmd_valid && prev_valid) pulse_err++;
            if (init_done && done_t < 0) begin
                done_t = cyc;
                ref_at_done = refresh_en;
            end
            prev_valid = cmd_valid;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic run_case(input logic [31:0] tm, input logic [31:0] g0, input logic [31:0] g1,
                            input logic [31:0] ov, input logic [31:0] pay);
        logic [31:0] exp_w;
        rst = 1'b1;
        cfg_timing = tm; cfg_grp0 = g0; cfg_grp1 = g1; cfg_mode_ovr = ov;
        repeat (3) @(negedge clk);
        n_cmd = 0; done_t = -1; pulse_err = 0; prev_valid = 1'b0;
        check(!cmd_valid && !init_done && !refresh_en, "R1 reset outputs",
              {29'd0, cmd_valid, init_done, refresh_en}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(grp0_out == g0, "R1 grp0 latched", grp0_out, g0);
        check(grp1_out == g1, "R1 grp1 latched", grp1_out, g1);
        check(timing_out == (tm & ~RMASK), "R1 timing refresh cleared", timing_out, tm & ~RMASK);
        check(n_cmd == 0, "R1 no command before latch", n_cmd, 0);
        for (int k = 0; k < 3 * W200 && !init_done; k++) @(negedge clk);
        check(init_done, "R10 done reached", {31'd0, init_done}, 32'd1);
        repeat (20) @(negedge clk);
        check(n_cmd == NCMD, "R4 command count", n_cmd, NCMD);
        check(pulse_err == 0, "R6 single-cycle pulses", pulse_err, 0);
        if (n_cmd >= NCMD) begin
            check(w_cmd[0] == 32'd0, "R2 first is NOP", w_cmd[0], 32'd0);
            check(t_cmd[1] - t_cmd[0] == W200 + 1, "R3 power-up wait",
                  t_cmd[1] - t_cmd[0], W200 + 1);
            for (int i = 1; i < NCMD; i++) begin
                exp_w = pay | ((i == 1) ? 32'd1 : (i == NCMD - 1) ? 32'd3 : 32'd2);
                check(w_cmd[i] == exp_w, "R4 R7 R8 R9 command word", w_cmd[i], exp_w);
                if (i > 1)
                    check(t_cmd[i] - t_cmd[i-1] == WCMD + 1, "R5 command spacing",
                          t_cmd[i] - t_cmd[i-1], WCMD + 1);
            end
            check(done_t - t_cmd[NCMD-1] == WCMD + 1, "R10 done timing",
                  done_t - t_cmd[NCMD-1], WCMD + 1);
        end
        check(timing_out == tm, "R10 full timing applied", timing_out, tm);
        check(ref_at_done == ((tm & RMASK) != 0), "R10 refresh with done",
              {31'd0, ref_at_done}, {31'd0, (tm & RMASK) != 0});
        check(refresh_en == ((tm & RMASK) != 0), "R10 refresh level",
              {31'd0, refresh_en}, {31'd0, (tm & RMASK) != 0});
        check(init_done && n_cmd == NCMD, "R11 sticky done, no extra commands", n_cmd, NCMD);
    endtask

    task automatic case_cl2_w32; run_case(32'h0000_1002, 32'h0000_0011, 32'h0000_0022, 32'd0, 32'h100); endtask // R7
    task automatic case_cl3_w32; run_case(32'h0000_2003, 32'h0000_0100, 32'h0000_0033, 32'd0, 32'h180); endtask // R7
    task automatic case_cl2_w16; run_case(32'h0000_3002, 32'h0000_0200, 32'h0000_0044, 32'd0, 32'h080); endtask // R8
    task automatic case_cl3_w16; run_case(32'h0000_1003, 32'h0000_0255, 32'h0000_0055, 32'd0, 32'h0C0); endtask // R8
    task automatic case_ovr;     run_case(32'h0000_1002, 32'h0000_0200, 32'h0000_0066, 32'h0000_0A50, 32'h0A50); endtask // R9
    task automatic case_noref;   run_case(32'h0000_0005, 32'h0000_0000, 32'h0000_0077, 32'd0, 32'h180); endtask // R10

    initial begin
        case_cl2_w32();
        case_cl3_w32();
        case_cl2_w16();
        case_cl3_w16();
        case_ovr();
        case_noref();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=<190000 cycles", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule